// File: doc/BRIEF.md
# Rewind FIFO

A single-clock first-in first-out buffer, 18 bits wide, whose depth is a parameter. Words enter on a write enable and leave on a read that needs two enables. Five status outputs come with it: empty, full, half-full, almost-empty and almost-full. The almost thresholds come from two offset registers. A per-flag mode bit chooses whether each of the three intermediate flags follows the occupancy at once or one clock later through an extra register.

A rewind input sends the read side back to storage address zero, so everything written since reset can be read again, for example to replay a packet after an error. A rewind before any word has ever been written does nothing. The offsets and mode bits are loaded through the write data bus while a load control is high. During a load, no data moves.

Top module: `rewind_fifo`

## Requirements
- R1: After reset, empty=1, full=0, half_full=0, almost_empty=1, almost_full=0 and rd_data=0. Both offsets are 8 and all three intermediate flags are in immediate mode.
- R2: A read fires when rd_en=1, rd_en2=1, cfg_ld=0 and the buffer is not empty. Words come out in the order they were written. rd_data takes the new word on the read edge and holds it until the next read.
- R3: A write is ignored while the occupancy is DEPTH, and a read is ignored while it is 0. A later read then shows no trace of the dropped word, and rd_data holds its value across the dropped read.
- R4: After each clock edge, empty is 1 exactly when the occupancy before that edge was 0. full is 1 exactly when it was DEPTH. Both flags lag the count by one cycle.
- R5: half_full is high when the occupancy exceeds DEPTH/2.
- R6: almost_empty is high when the occupancy is at or below the empty offset. almost_full is high when the occupancy is at or above DEPTH minus the full offset. With cfg_ld=1, cfg_sel=0 loads the empty offset and cfg_sel=1 loads the full offset, both from wr_data[AW-1:0]. cfg_sel=3 changes nothing.
- R7: With cfg_ld=1 and cfg_sel=2, wr_data[0], [1] and [2] load the mode bits for almost_empty, half_full and almost_full. A 0 makes the flag show the occupancy after the same edge. A 1 makes it show the value from one edge earlier.
- R8: A rewind (rt=1, once anything has been written) is taken whatever rd_en is. It sets the read address to 0 and sets the occupancy to the write address, or to DEPTH when that address has wrapped to 0. In that cycle, no read or write occurs. The next read returns the word stored at address 0.
- R9: A rewind before any write since reset changes no address, occupancy, flag or rd_data.
- R10: After a rewind, empty and full are correct one edge later. Immediate-mode intermediate flags are correct from the rewind edge, and registered ones one edge later. Both are within the three- and four-cycle settling budgets.
- R11: While cfg_ld=1, no word is written or read. A low rd_en2 blocks a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write word; also configuration data during a load |
| rd_en | input | 1 | Primary read enable |
| rd_en2 | input | 1 | Secondary read enable |
| cfg_ld | input | 1 | Configuration load; blocks data movement |
| cfg_sel | input | 2 | Load target: 0 empty offset, 1 full offset, 2 mode bits, 3 none |
| rt | input | 1 | Rewind request |
| rd_data | output | W | Last word read |
| empty | output | 1 | Buffer empty (one-cycle lag) |
| full | output | 1 | Buffer full (one-cycle lag) |
| half_full | output | 1 | Occupancy above half |
| almost_empty | output | 1 | Occupancy at or below empty offset |
| almost_full | output | 1 | Occupancy at or above DEPTH minus full offset |

## Verification
The 16-deep default is swept from empty through full plus one refused write, then drained past empty. This is done with default offsets, with odd offsets in registered mode, and with the extreme offsets 0 and 15 in mixed modes. Each edge's flags are compared against arithmetic on a model count, which separates off-by-one threshold errors and immediate versus delayed flag paths. A pseudo-patterned run of mixed reads, writes, dropped secondary enables and empty loads separates the gating terms. Rewinds are tried with nothing written, after a partial drain, after a full drain in registered mode, and after a wrapped full write. These cases tell apart the zero-address restart, the DEPTH count on wrap and the no-op rule.

// File: rtl/rewind_fifo_pkg.sv
`timescale 1ns/1ps
// Shared types for the rewind FIFO.
// Assumes: intermediate flag order AE, HF, AF is fixed (it matches the mode bit order).
package rewind_fifo_pkg;
    typedef enum logic [1:0] {
        SEL_AE_OFF = 2'd0,
        SEL_AF_OFF = 2'd1,
        SEL_MODE   = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    localparam int NUM_MID = 3;
    localparam int MID_AE  = 0;
    localparam int MID_HF  = 1;
    localparam int MID_AF  = 2;
endpackage

// File: rtl/rewind_fifo_store.sv
`timescale 1ns/1ps
// Storage array with a registered read port.
// Assumes: the control block never asserts wr_fire and rd_fire for illegal states.
module rewind_fifo_store #(
    parameter int W     = 18,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_fire,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rd_q;

    // store an accepted word
    always_ff @(posedge clk) begin
        if (wr_fire) mem[wr_addr] <= wr_data;
    end

    // capture the word at the read address on an accepted read
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_fire) rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rd_q));
endmodule

// File: rtl/rewind_fifo_ptrs.sv
`timescale 1ns/1ps
// Address and occupancy control, including the rewind to address zero.
// Assumes: no more than DEPTH words are written between reset and a rewind
// if the replay is to be complete.
module rewind_fifo_ptrs #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          rt,
    output logic          wr_fire,
    output logic          rd_fire,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;
    logic          written_q;
    logic          rt_fire;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // a rewind counts only once something has been written
    assign rt_fire = rt && written_q;
    assign wr_fire = wr_req && !rt_fire && (count_q != FULL_CNT);
    assign rd_fire = rd_req && !rt_fire && (count_q != '0);

    // write address and the written-since-reset marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= '0;
            written_q <= 1'b0;
        end else if (wr_fire) begin
            wr_q      <= bump(wr_q);
            written_q <= 1'b1;
        end
    end

    // read address and occupancy, rewind taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= '0;
            count_q <= '0;
        end else if (rt_fire) begin
            rd_q    <= '0;
            count_q <= (wr_q == '0) ? FULL_CNT : CW'(wr_q);
        end else begin
            if (rd_fire) rd_q <= bump(rd_q);
            unique case ({wr_fire, rd_fire})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign wr_addr = wr_q;
    assign rd_addr = rd_q;
    assign count   = count_q;

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);
    // R3
    no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == FULL_CNT) |=> $stable(wr_q));
    // R3
    no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !rt) |=> $stable(rd_q));
    // R8
    rewind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rt && written_q) |=> (rd_q == '0));
    // R9
    rewind_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!written_q && !wr_req) |=> (count_q == '0 && rd_q == '0));
endmodule

// File: rtl/rewind_fifo_flags.sv
`timescale 1ns/1ps
// Status flags, almost-flag offsets and per-flag immediate/registered mode.
// Assumes: offsets fit in AW bits and AW >= NUM_MID so mode bits fit the config bus.
module rewind_fifo_flags
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int AW     = $clog2(DEPTH),
    parameter int CW     = $clog2(DEPTH + 1),
    parameter int AE_DEF = 8,
    parameter int AF_DEF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          cfg_ld,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_data,
    output logic          empty,
    output logic          full,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
    localparam logic [NUM_MID-1:0] RAW_RST = NUM_MID'(1 << MID_AE);

    cfg_sel_e           sel;
    logic [AW-1:0]      ae_off_q, af_off_q;
    logic [NUM_MID-1:0] mode_q, raw, mid;
    logic               empty_q, full_q;

    assign sel = cfg_sel_e'(cfg_sel);

    // configuration registers loaded from the data bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_off_q <= AW'(AE_DEF);
            af_off_q <= AW'(AF_DEF);
            mode_q   <= '0;
        end else if (cfg_ld) begin
            unique case (sel)
                SEL_AE_OFF: ae_off_q <= cfg_data;
                SEL_AF_OFF: af_off_q <= cfg_data;
                SEL_MODE:   mode_q   <= cfg_data[NUM_MID-1:0];
                default:    ;
            endcase
        end
    end

    // threshold comparisons on the live occupancy
    always_comb begin
        raw[MID_AE] = (count <= CW'(ae_off_q));
        raw[MID_HF] = (count >  HALF_CNT);
        raw[MID_AF] = (count >= (FULL_CNT - CW'(af_off_q)));
    end

    // boundary flags registered from the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            empty_q <= (count == '0);
            full_q  <= (count == FULL_CNT);
        end
    end

    for (genvar g = 0; g < NUM_MID; g++) begin : g_mid
        logic st_q;

        // optional extra stage for this intermediate flag
        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= RAW_RST[g];
            else        st_q <= raw[g];
        end

        assign mid[g] = mode_q[g] ? st_q : raw[g];

        // R7
        mid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[g] && $past(mode_q[g])) |-> (mid[g] == $past(raw[g])));
    end

    assign empty        = empty_q;
    assign full         = full_q;
    assign almost_empty = mid[MID_AE];
    assign half_full    = mid[MID_HF];
    assign almost_full  = mid[MID_AF];

    // R4
    empty_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> empty_q);
    // R4
    full_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != FULL_CNT) |=> !full_q);
endmodule

// File: rtl/rewind_fifo.sv
`timescale 1ns/1ps
// Rewind FIFO top: single-clock buffer with a replay-from-zero request.
// Assumes: DEPTH >= 16 so that the default offsets fit and stay below DEPTH.
module rewind_fifo #(
    parameter int W      = 18,
    parameter int DEPTH  = 16,
    parameter int AE_DEF = 8,
    parameter int AF_DEF = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic         rd_en2,
    input  logic         cfg_ld,
    input  logic [1:0]   cfg_sel,
    input  logic         rt,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    output logic         half_full,
    output logic         almost_empty,
    output logic         almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_req, rd_req, wr_fire, rd_fire;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] count;

    // a load cycle moves no data; reads need both enables
    assign wr_req = wr_en && !cfg_ld;
    assign rd_req = rd_en && rd_en2 && !cfg_ld;

    rewind_fifo_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .rt(rt),
        .wr_fire(wr_fire), .rd_fire(rd_fire), .wr_addr(wr_addr),
        .rd_addr(rd_addr), .count(count)
    );

    rewind_fifo_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    rewind_fifo_flags #(.DEPTH(DEPTH), .AW(AW), .CW(CW),
                        .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_flags (
        .clk(clk), .rst_n(rst_n), .count(count), .cfg_ld(cfg_ld),
        .cfg_sel(cfg_sel), .cfg_data(wr_data[AW-1:0]),
        .empty(empty), .full(full), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    // R11
    load_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ld |-> (!wr_fire && !rd_fire));
endmodule

// File: tb/rewind_fifo_bench.sv
`timescale 1ns/1ps
// Bench: per-cycle comparison against an arithmetic model of a 16-deep buffer.
module rewind_fifo_bench;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rd_en2 = 1'b0, cfg_ld = 1'b0, rt = 1'b0;
    logic [17:0] wr_data = '0;
    logic [1:0]  cfg_sel = '0;
    logic [17:0] rd_data;
    logic        empty, full, half_full, almost_empty, almost_full;

    int total = 0;
    int fails = 0;

    // model state
    int          m_cnt, m_wp, m_rp, ae_off, af_off;
    bit          m_written;
    bit [2:0]    mode;
    logic [17:0] m_mem [D];
    logic [17:0] m_rd;

    rewind_fifo u_rewind_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_en2(rd_en2), .cfg_ld(cfg_ld), .cfg_sel(cfg_sel),
        .rt(rt), .rd_data(rd_data), .empty(empty), .full(full),
        .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic bit [2:0] rawf(input int c);
        rawf[0] = (c <= ae_off);
        rawf[1] = (c > D / 2);
        rawf[2] = (c >= D - af_off);
    endfunction

    task automatic do_reset();
        wr_en = 0; rd_en = 0; rd_en2 = 0; cfg_ld = 0; rt = 0; cfg_sel = 0; wr_data = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_cnt = 0; m_wp = 0; m_rp = 0; m_written = 0;
        ae_off = 8; af_off = 8; mode = 3'b000; m_rd = '0;
    endtask

    // one clock cycle of stimulus, model update and full output comparison
    task automatic cyc(input bit we, input logic [17:0] d, input bit re, input bit re2,
                       input bit ld, input logic [1:0] sel, input bit rtq,
                       input string ftag, input string dtag);
        bit [2:0] rawb, rawa, expm;
        bit eb, fb, rtf, wf, rf;
        string htag;
        wr_en = we; wr_data = d; rd_en = re; rd_en2 = re2;
        cfg_ld = ld; cfg_sel = sel; rt = rtq;
        rawb = rawf(m_cnt);
        eb = (m_cnt == 0);
        fb = (m_cnt == D);
        rtf = rtq && m_written;
        wf = we && !ld && !rtf && (m_cnt != D);
        rf = re && re2 && !ld && !rtf && (m_cnt != 0);
        if (ld) begin
            case (sel)
                2'd0: ae_off = int'(d[3:0]);
                2'd1: af_off = int'(d[3:0]);
                2'd2: mode = d[2:0];
                default: ;
            endcase
        end
        if (wf) begin
            m_mem[m_wp] = d;
            m_wp = (m_wp + 1) % D;
            m_written = 1;
        end
        if (rtf) begin
            m_rp = 0;
            m_cnt = (m_wp == 0) ? D : m_wp;
        end else begin
            if (rf) begin
                m_rd = m_mem[m_rp];
                m_rp = (m_rp + 1) % D;
            end
            m_cnt = m_cnt + int'(wf) - int'(rf);
        end
        rawa = rawf(m_cnt);
        for (int i = 0; i < 3; i++) expm[i] = mode[i] ? rawb[i] : rawa[i];
        @(posedge clk);
        #1;
        htag = (ftag == "R6") ? "R5" : ftag;
        chk("R4", "empty", 32'(empty), 32'(eb));
        chk("R4", "full", 32'(full), 32'(fb));
        chk(ftag, "almost_empty", 32'(almost_empty), 32'(expm[0]));
        chk(htag, "half_full", 32'(half_full), 32'(expm[1]));
        chk(ftag, "almost_full", 32'(almost_full), 32'(expm[2]));
        chk(dtag, "rd_data", 32'(rd_data), 32'(m_rd));
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, 2'd0, 0, tag, tag);
    endtask

    task automatic load(input logic [1:0] sel, input logic [17:0] v);
        cyc(1, v, 1, 1, 1, sel, 0, "R7", "R11");
    endtask

    task automatic fill_drain(input string ftag, input int base);
        for (int i = 0; i <= D; i++) cyc(1, 18'(base + i), 0, 0, 0, 2'd0, 0, ftag, "R3");
        for (int i = 0; i < D; i++)  cyc(0, '0, 1, 1, 0, 2'd0, 0, ftag, "R2");
        cyc(0, '0, 1, 1, 0, 2'd0, 0, ftag, "R3");
        idle(2, ftag);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        total++;
        $display("FAIL watchdog expired actual running expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1", "empty", 32'(empty), 1);
        chk("R1", "full", 32'(full), 0);
        chk("R1", "half_full", 32'(half_full), 0);
        chk("R1", "almost_empty", 32'(almost_empty), 1);
        chk("R1", "almost_full", 32'(almost_full), 0);
        chk("R1", "rd_data", 32'(rd_data), 0);

        // R9: rewind with nothing written, with and without read enable
        cyc(0, '0, 1, 1, 0, 2'd0, 1, "R9", "R9");
        cyc(0, '0, 0, 0, 0, 2'd0, 1, "R9", "R9");
        idle(2, "R9");
        cyc(1, 18'h2A, 0, 0, 0, 2'd0, 0, "R9", "R9");
        cyc(0, '0, 1, 1, 0, 2'd0, 0, "R9", "R9");

        // R2 R3 R5 R6: default offsets, full sweep up and down
        do_reset();
        fill_drain("R6", 18'h100);

        // R11: mixed traffic with blocked enables and empty loads
        for (int i = 0; i < 48; i++)
            cyc(i % 3 != 2, 18'(18'h3000 + i), i % 2 == 1, i % 5 != 0,
                i % 7 == 6, 2'd3, 0, "R6", "R11");
        for (int i = 0; i < 20; i++) cyc(0, '0, 1, 1, 0, 2'd0, 0, "R6", "R11");

        // R7: odd offsets, all flags registered
        load(2'd0, 18'd3);
        load(2'd1, 18'd5);
        load(2'd2, 18'b111);
        fill_drain("R7", 18'h200);

        // R6: extreme offsets, mixed modes
        load(2'd0, 18'd0);
        load(2'd1, 18'd15);
        load(2'd2, 18'b010);
        fill_drain("R6", 18'h300);

        // R8 R10: partial fill, partial drain, rewind with read enable high
        do_reset();
        for (int i = 0; i < 5; i++) cyc(1, 18'(18'h400 + i), 0, 0, 0, 2'd0, 0, "R10", "R8");
        for (int i = 0; i < 2; i++) cyc(0, '0, 1, 1, 0, 2'd0, 0, "R10", "R8");
        cyc(1, 18'h3FFFF, 1, 1, 0, 2'd0, 1, "R10", "R8");
        idle(5, "R10");
        for (int i = 0; i < 6; i++) cyc(0, '0, 1, 1, 0, 2'd0, 0, "R10", "R8");

        // R8 R10: registered flags, drained to empty, then rewind
        do_reset();
        load(2'd2, 18'b111);
        for (int i = 0; i < 10; i++) cyc(1, 18'(18'h500 + i), 0, 0, 0, 2'd0, 0, "R10", "R8");
        for (int i = 0; i < 10; i++) cyc(0, '0, 1, 1, 0, 2'd0, 0, "R10", "R8");
        cyc(0, '0, 0, 0, 0, 2'd0, 1, "R10", "R8");
        idle(5, "R10");
        for (int i = 0; i < 11; i++) cyc(0, '0, 1, 1, 0, 2'd0, 0, "R10", "R8");

        // R8: wrapped write address gives a full replay
        do_reset();
        for (int i = 0; i < D; i++) cyc(1, 18'(18'h600 + i), 0, 0, 0, 2'd0, 0, "R10", "R8");
        for (int i = 0; i < 3; i++) cyc(0, '0, 1, 1, 0, 2'd0, 0, "R10", "R8");
        cyc(0, '0, 1, 0, 0, 2'd0, 1, "R10", "R8");
        idle(4, "R10");
        for (int i = 0; i <= D; i++) cyc(0, '0, 1, 1, 0, 2'd0, 0, "R10", "R8");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule